// File: doc/BRIEF.md
# Tightly-Coupled Memory Wait-State Generator and DMA Arbiter

This block connects a processor's tightly-coupled memory port and a DMA controller to one single-port synchronous SRAM. Each cycle it picks one of three sources for the memory's chip enable, address, byte-lane write enables, direction and write data. The sources are the live processor request, the DMA request, or a captured copy of a processor request that DMA held off. It also produces the processor's wait signal.

DMA always wins the memory. While DMA holds it, the processor is stalled, and a processor request that arrives during DMA is copied into a capture register. The first cycle after DMA lets go, the memory is driven from that register. A processor access marked nonsequential gets one wait cycle before the memory sees it. A sequential access goes straight through. Once DMA has used the memory, the next processor access that was not captured is treated as nonsequential whatever its flag says.

The memory returns read data in the same cycle as the access it is given. The block steers that data to the processor only in the cycle the processor access completes, and to the DMA side only on DMA cycles. Elsewhere both read buses are zero. Reset is asynchronous and active low.

Top module: `tcm_dma_arbiter`

## Requirements
- R1: During and after reset, `cpu_wait` and `mem_ce` are 0, no capture is pending and no forced-nonsequential state is set, so a first processor access with `cpu_seq`=1 completes with no wait.
- R2: A processor access with `cpu_seq`=0 and no DMA gets exactly one cycle with `cpu_wait`=1 and `mem_ce`=0. In the next cycle the same request goes to the memory with `cpu_wait`=0.
- R3: A processor access with `cpu_seq`=1 and no forced-nonsequential state completes in the cycle it is presented. The memory is driven from the processor port and `cpu_wait`=0.
- R4: In any cycle with `dma_req`=1, the memory is driven from the DMA port (`mem_ce`=1). `cpu_wait` equals `cpu_req` in that cycle.
- R5: A processor request present during a DMA cycle is captured. In the first cycle with `dma_req`=0 the memory is driven from the captured values with `cpu_wait`=0, and no further wait is added.
- R6: After any DMA cycle, the next processor access that was not captured gets the single wait cycle of R2, even with `cpu_seq`=1.
- R7: `mem_wdata` carries the write data of the same source as the address: DMA, live processor or captured processor. It is zero when no access is issued.
- R8: `cpu_rdata` equals `mem_rdata` only in a cycle that completes a processor access (live or captured) and is zero otherwise. `dma_rdata` equals `mem_rdata` only when `dma_req`=1 and is zero otherwise.
- R9: With `cpu_req`=0, `dma_req`=0 and no capture pending, `mem_ce`=0, `cpu_wait`=0, and the memory address, byte enables, direction and write data are all zero.
- R10: Direction encoding: `cpu_wr`, `dma_wr` and `mem_we` are 1 for a write. Bit i of a byte enable covers data bits 8i+7 to 8i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cpu_req | input | 1 | Processor chip select; held while `cpu_wait` is high |
| cpu_seq | input | 1 | Processor access is sequential to the previous one |
| cpu_wr | input | 1 | Processor direction, 1 = write |
| cpu_addr | input | 18 | Processor word address |
| cpu_be | input | 4 | Processor byte-lane write enables |
| cpu_wdata | input | 32 | Processor write data |
| cpu_rdata | output | 32 | Read data to processor |
| cpu_wait | output | 1 | Processor stall |
| dma_req | input | 1 | DMA wants the memory this cycle |
| dma_wr | input | 1 | DMA direction, 1 = write |
| dma_addr | input | 18 | DMA word address |
| dma_be | input | 4 | DMA byte-lane write enables |
| dma_wdata | input | 32 | DMA write data |
| dma_rdata | output | 32 | Read data to DMA |
| mem_ce | output | 1 | SRAM chip enable |
| mem_we | output | 1 | SRAM direction, 1 = write |
| mem_be | output | 4 | SRAM byte-lane write enables |
| mem_addr | output | 18 | SRAM address |
| mem_wdata | output | 32 | SRAM write data |
| mem_rdata | input | 32 | SRAM read data for this cycle's access |

## Verification
Every port result is combinational from the current inputs and the registered state: source selection, memory drives, `cpu_wait` and read-data routing. So each result is due in the same cycle as its stimulus. The capture register, the nonsequential loopback and the forced-nonsequential flag update at the next rising edge. Their effect therefore shows one cycle later: the completion after a nonsequential wait, the replay after DMA drops, and the forced wait on the next processor access. The bench drives inputs just after the falling edge and compares every output 2 ns later, against a reference model that advances its own state once per cycle. This lands each check in the cycle where the result is due.

// File: rtl/tcm_arb_pkg.sv
package tcm_arb_pkg;
  typedef enum logic [1:0] {
    SRC_IDLE = 2'd0,
    SRC_CPU  = 2'd1,
    SRC_DMA  = 2'd2,
    SRC_CAP  = 2'd3
  } src_e;
endpackage

// File: rtl/tcm_arb_ctrl.sv
module tcm_arb_ctrl
  import tcm_arb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_seq,
  input  logic dma_req,
  output src_e src,
  output logic cpu_wait,
  output logic cap_load,
  output logic cpu_done
);
  logic cap_valid_q, cap_valid_d;
  logic force_ns_q, force_ns_d;
  logic ns_done_q, ns_done_d;
  logic treat_nseq;

  // loopback of the sequential flag, overridden after DMA activity
  assign treat_nseq = !cpu_seq || force_ns_q;

  always_comb begin
    src         = SRC_IDLE;
    cpu_wait    = 1'b0;
    cap_load    = 1'b0;
    cpu_done    = 1'b0;
    cap_valid_d = cap_valid_q;
    force_ns_d  = force_ns_q;
    ns_done_d   = 1'b0;
    if (dma_req) begin
      src        = SRC_DMA;
      cpu_wait   = cpu_req;
      force_ns_d = 1'b1;
      if (cpu_req && !cap_valid_q) begin
        cap_load    = 1'b1;
        cap_valid_d = 1'b1;
      end
    end else if (cap_valid_q) begin
      src         = SRC_CAP;
      cpu_done    = 1'b1;
      cap_valid_d = 1'b0;
      force_ns_d  = 1'b0;
    end else if (cpu_req) begin
      if (treat_nseq && !ns_done_q) begin
        cpu_wait  = 1'b1;
        ns_done_d = 1'b1;
      end else begin
        src        = SRC_CPU;
        cpu_done   = 1'b1;
        force_ns_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid_q <= 1'b0;
      force_ns_q  <= 1'b0;
      ns_done_q   <= 1'b0;
    end else begin
      cap_valid_q <= cap_valid_d;
      force_ns_q  <= force_ns_d;
      ns_done_q   <= ns_done_d;
    end
  end
endmodule

// File: rtl/tcm_arb_capture.sv
module tcm_arb_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic [BE_W-1:0]   be_q,
  output logic              wr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (load) begin
      addr_q  <= addr_i;
      be_q    <= be_i;
      wr_q    <= wr_i;
      wdata_q <= wdata_i;
    end
  end
endmodule

// File: rtl/tcm_arb_mux.sv
module tcm_arb_mux
  import tcm_arb_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  src_e              src,
  input  logic              cpu_done,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [BE_W-1:0]   dma_be,
  input  logic              dma_wr,
  input  logic [DATA_W-1:0] dma_wdata,
  input  logic [ADDR_W-1:0] cap_addr,
  input  logic [BE_W-1:0]   cap_be,
  input  logic              cap_wr,
  input  logic [DATA_W-1:0] cap_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] dma_rdata
);
  always_comb begin
    mem_ce    = 1'b1;
    mem_we    = 1'b0;
    mem_be    = '0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (src)
      SRC_CPU: begin
        mem_we = cpu_wr; mem_be = cpu_be; mem_addr = cpu_addr; mem_wdata = cpu_wdata;
      end
      SRC_DMA: begin
        mem_we = dma_wr; mem_be = dma_be; mem_addr = dma_addr; mem_wdata = dma_wdata;
      end
      SRC_CAP: begin
        mem_we = cap_wr; mem_be = cap_be; mem_addr = cap_addr; mem_wdata = cap_wdata;
      end
      default: mem_ce = 1'b0;
    endcase
  end

  assign cpu_rdata = cpu_done ? mem_rdata : '0;
  assign dma_rdata = (src == SRC_DMA) ? mem_rdata : '0;
endmodule

// File: rtl/tcm_dma_arbiter.sv
module tcm_dma_arbiter #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_seq,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [BE_W-1:0]   cpu_be,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_wait,
  input  logic              dma_req,
  input  logic              dma_wr,
  input  logic [ADDR_W-1:0] dma_addr,
  input  logic [BE_W-1:0]   dma_be,
  input  logic [DATA_W-1:0] dma_wdata,
  output logic [DATA_W-1:0] dma_rdata,
  output logic              mem_ce,
  output logic              mem_we,
  output logic [BE_W-1:0]   mem_be,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  tcm_arb_pkg::src_e src;
  logic              cap_load, cpu_done;
  logic [ADDR_W-1:0] cap_addr;
  logic [BE_W-1:0]   cap_be;
  logic              cap_wr;
  logic [DATA_W-1:0] cap_wdata;

  tcm_arb_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_seq(cpu_seq),
    .dma_req(dma_req), .src(src), .cpu_wait(cpu_wait),
    .cap_load(cap_load), .cpu_done(cpu_done)
  );

  tcm_arb_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .load(cap_load),
    .addr_i(cpu_addr), .be_i(cpu_be), .wr_i(cpu_wr), .wdata_i(cpu_wdata),
    .addr_q(cap_addr), .be_q(cap_be), .wr_q(cap_wr), .wdata_q(cap_wdata)
  );

  tcm_arb_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_mux (
    .src(src), .cpu_done(cpu_done),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .dma_addr(dma_addr), .dma_be(dma_be), .dma_wr(dma_wr), .dma_wdata(dma_wdata),
    .cap_addr(cap_addr), .cap_be(cap_be), .cap_wr(cap_wr), .cap_wdata(cap_wdata),
    .mem_rdata(mem_rdata), .mem_ce(mem_ce), .mem_we(mem_we), .mem_be(mem_be),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cpu_rdata(cpu_rdata), .dma_rdata(dma_rdata)
  );
endmodule

// File: rtl/tcm_arb_checker.sv
module tcm_arb_checker #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              dma_req,
  input logic              cpu_wait,
  input logic              mem_ce,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] dma_addr,
  input logic [DATA_W-1:0] cpu_rdata
);
  // R4: a processor request during DMA is stalled
  a_r4_dma_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && cpu_req) |-> cpu_wait);

  // R4: DMA owns the memory port whenever it requests
  a_r4_dma_owns: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (mem_ce && mem_addr == dma_addr));

  // R2: a nonsequential wait lasts a single cycle when DMA stays away
  a_r2_single_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_wait && !dma_req) ##1 (cpu_req && !dma_req) |-> !cpu_wait);

  // R6: a fresh processor request right after DMA is made to wait
  a_r6_forced_nseq: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dma_req) && !$past(cpu_req) && !dma_req && cpu_req) |-> cpu_wait);

  // R9: nothing requested, nothing issued
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && !dma_req) |-> (!mem_ce && !cpu_wait));

  // R8: no read data leaks to the processor while it is stalled
  a_r8_rdata_gated: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wait |-> (cpu_rdata == '0));
endmodule

bind tcm_dma_arbiter tcm_arb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .dma_req(dma_req),
  .cpu_wait(cpu_wait), .mem_ce(mem_ce), .mem_addr(mem_addr),
  .dma_addr(dma_addr), .cpu_rdata(cpu_rdata)
);

// File: tb/test_tcm_dma_arbiter.sv
`timescale 1ns/1ps
module test_tcm_dma_arbiter;
  localparam int AW = 18;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cpu_req, cpu_seq, cpu_wr, dma_req, dma_wr;
  logic [AW-1:0] cpu_addr, dma_addr, mem_addr;
  logic [BW-1:0] cpu_be, dma_be, mem_be;
  logic [DW-1:0] cpu_wdata, dma_wdata, cpu_rdata, dma_rdata, mem_wdata, mem_rdata;
  logic cpu_wait, mem_ce, mem_we;

  always #4 clk = ~clk;

  tcm_dma_arbiter i_tcm_dma_arbiter (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_seq(cpu_seq), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_wait(cpu_wait), .dma_req(dma_req), .dma_wr(dma_wr), .dma_addr(dma_addr),
    .dma_be(dma_be), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata), .mem_ce(mem_ce),
    .mem_we(mem_we), .mem_be(mem_be), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  // environment memory: read returns the addressed word in the same cycle
  logic [DW-1:0] ram [16];
  assign mem_rdata = ram[mem_addr[3:0]];
  always_ff @(posedge clk)
    if (mem_ce && mem_we)
      for (int b = 0; b < BW; b++)
        if (mem_be[b]) ram[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];

  // reference model state
  typedef struct { logic [AW-1:0] a; logic [BW-1:0] be; logic wr; logic [DW-1:0] d; } held_t;
  held_t capq[$];
  logic [DW-1:0] shadow [16];
  bit m_force, m_nsdone, e_wait, done;
  int total, fails, dma_left, cyc;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic shadow_write(input logic [3:0] a, input logic [BW-1:0] be, input logic [DW-1:0] d);
    for (int b = 0; b < BW; b++) if (be[b]) shadow[a][8*b +: 8] = d[8*b +: 8];
  endtask

  // one cycle: inputs already set after the falling edge; compare, advance model
  task automatic tick();
    logic e_ce, e_we; logic [BW-1:0] e_be; logic [AW-1:0] e_addr;
    logic [DW-1:0] e_wd, e_crd, e_drd; string tg;
    dma_req   = (dma_left > 0);
    dma_wr    = dma_left[0];
    dma_addr  = AW'(8 + dma_left);
    dma_be    = 4'b1111;
    dma_wdata = 32'hD000_0000 + DW'(cyc);
    #2;
    e_ce = 0; e_we = 0; e_be = '0; e_addr = '0; e_wd = '0; e_crd = '0; e_drd = '0;
    e_wait = 0; tg = "R9";
    if (dma_req) begin
      tg = "R4"; e_ce = 1; e_we = dma_wr; e_be = dma_be; e_addr = dma_addr; e_wd = dma_wdata;
      e_drd = shadow[dma_addr[3:0]]; e_wait = cpu_req;
      if (cpu_req && capq.size() == 0) capq.push_back('{cpu_addr, cpu_be, cpu_wr, cpu_wdata});
      if (dma_wr) shadow_write(dma_addr[3:0], dma_be, dma_wdata);
      m_force = 1; m_nsdone = 0;
    end else if (capq.size() != 0) begin
      held_t h = capq.pop_front();
      tg = "R5"; e_ce = 1; e_we = h.wr; e_be = h.be; e_addr = h.a; e_wd = h.d;
      e_crd = shadow[h.a[3:0]];
      if (h.wr) shadow_write(h.a[3:0], h.be, h.d);
      m_force = 0; m_nsdone = 0;
    end else if (cpu_req) begin
      if ((!cpu_seq || m_force) && !m_nsdone) begin
        tg = m_force ? "R6" : "R2"; e_wait = 1; m_nsdone = 1;
      end else begin
        tg = m_nsdone ? "R2" : "R3"; e_ce = 1; e_we = cpu_wr; e_be = cpu_be;
        e_addr = cpu_addr; e_wd = cpu_wdata; e_crd = shadow[cpu_addr[3:0]];
        if (cpu_wr) shadow_write(cpu_addr[3:0], cpu_be, cpu_wdata);
        m_force = 0; m_nsdone = 0;
      end
    end else m_nsdone = 0;
    chk(cpu_wait == e_wait, tg, "cpu_wait", 64'(cpu_wait), 64'(e_wait));
    chk(mem_ce == e_ce, tg, "mem_ce", 64'(mem_ce), 64'(e_ce));
    chk(mem_we == e_we, "R10", "mem_we", 64'(mem_we), 64'(e_we));
    chk(mem_be == e_be, "R10", "mem_be", 64'(mem_be), 64'(e_be));
    chk(mem_addr == e_addr, tg, "mem_addr", 64'(mem_addr), 64'(e_addr));
    chk(mem_wdata == e_wd, "R7", "mem_wdata", 64'(mem_wdata), 64'(e_wd));
    chk(cpu_rdata == e_crd, "R8", "cpu_rdata", 64'(cpu_rdata), 64'(e_crd));
    chk(dma_rdata == e_drd, "R8", "dma_rdata", 64'(dma_rdata), 64'(e_drd));
    @(negedge clk);
    if (dma_left > 0) dma_left--;
    cyc++;
  endtask

  // present a processor access and hold it until the model says it completes
  task automatic cpu_op(input logic [AW-1:0] a, input bit seq, input bit wr,
                        input logic [BW-1:0] be, input logic [DW-1:0] d, input int dma_at);
    cpu_req = 1; cpu_seq = seq; cpu_wr = wr; cpu_addr = a; cpu_be = be; cpu_wdata = d;
    for (int n = 0; n < 30; n++) begin
      if (n == 1 && dma_at > 0) dma_left = dma_at;
      tick();
      if (!e_wait) break;
    end
  endtask

  task automatic idle(input int n);
    cpu_req = 0; cpu_seq = 0; cpu_wr = 0; cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; total++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    done = 0; total = 0; fails = 0; dma_left = 0; cyc = 0; m_force = 0; m_nsdone = 0;
    for (int i = 0; i < 16; i++) begin
      ram[i] = 32'hA5A5_0000 + DW'(i); shadow[i] = 32'hA5A5_0000 + DW'(i);
    end
    rst_n = 0; cpu_req = 0; cpu_seq = 0; cpu_wr = 0; cpu_addr = '0; cpu_be = '0;
    cpu_wdata = '0; dma_req = 0; dma_wr = 0; dma_addr = '0; dma_be = '0; dma_wdata = '0;
    @(negedge clk); @(negedge clk); #2;
    chk(cpu_wait == 0, "R1", "reset cpu_wait", 64'(cpu_wait), 64'h0);
    chk(mem_ce == 0, "R1", "reset mem_ce", 64'(mem_ce), 64'h0);
    @(negedge clk); rst_n = 1;
    // R1: sequential first access completes at once
    cpu_op(18'd1, 1, 1, 4'b1111, 32'h1111_1111, 0);
    cpu_op(18'd2, 0, 1, 4'b0011, 32'h2222_2222, 0);   // R2
    cpu_op(18'd3, 1, 1, 4'b1100, 32'h3333_3333, 0);   // R3
    cpu_op(18'd2, 0, 0, 4'b0000, '0, 0);              // R2 read, R8
    cpu_op(18'd3, 1, 0, 4'b0000, '0, 0);              // R3 read
    idle(2);                                          // R9
    dma_left = 3; idle(4);                            // R4 alone, then idle
    cpu_op(18'd9, 1, 0, 4'b0000, '0, 0);              // R6 forced wait
    cpu_op(18'd10, 1, 0, 4'b0000, '0, 0);             // R3 after force cleared
    dma_left = 3;
    cpu_op(18'd4, 1, 1, 4'b1111, 32'h4444_4444, 0);   // R5 capture, R7 data
    cpu_op(18'd4, 1, 0, 4'b0000, '0, 0);              // read back replayed write
    cpu_op(18'd5, 0, 1, 4'b0101, 32'h5555_5555, 2);   // DMA during nonseq wait, R5
    cpu_op(18'd5, 1, 0, 4'b0000, '0, 0);
    idle(1);
    dma_left = 2;
    cpu_op(18'd11, 0, 0, 4'b0000, '0, 0);             // captured read during DMA
    idle(3);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule